// File: doc/BRIEF.md
# UART Receive Queue with Level Interrupt

This block stores characters delivered by a serial receiver, together with their per-character error flags. It presents the oldest stored character to the register-read side of a UART. Reading the data register pops that character. The block keeps a read pointer and an occupancy count. From them it derives the empty, full and can-accept indications, and it raises a receive-level interrupt request when the occupancy reaches a trigger level.

The queue has two modes, chosen at run time by a queue-enable level taken from the line control register. When the queue is enabled it holds 16 entries. When it is disabled it acts as a single holding register. Any change of the enable level flushes the queue. In that same cycle the block pulses an output that tells the transmit side to reset its own flags.

A line break seen by the receiver is stored as its own entry, marked as a break, unless loopback is active. A push that arrives while the queue is full is discarded, and the newest stored entry is then marked with an overrun flag. The error flags of the most recently read entry are kept in a receive status register, which a write clears.

Top module: `uart_rx_queue`

## Requirements
- R1: After reset `rx_empty`=1, `rx_full`=0, `can_accept`=1, `rx_irq`=0, `rx_status`=0, `tx_flush`=0, and the queue is in disabled (single-entry) mode.
- R2: The effective depth is 16 while the mode is enabled and 1 while it is disabled. `rx_full` is 1 exactly when the count equals the effective depth. `can_accept` is 1 exactly when the count is below it. `rx_empty` is 1 exactly when the count is zero.
- R3: Entries leave in push order, and the pointer wraps around the storage. `rd_entry` shows the oldest entry with this layout: bits [7:0] data, bit 8 framing error, bit 9 parity error, bit 10 break, bit 11 overrun.
- R4: A `pop` while the queue is empty changes neither the count nor the pointer, so `rx_empty` stays 1 and `rx_full` stays 0.
- R5: In a cycle where `fifo_en` differs from the current mode, `tx_flush` is 1. The edge that ends that cycle adopts the new mode and empties the queue, and any push or pop in that cycle is ignored.
- R6: `rx_irq` is set when a push makes the count equal the trigger, which defaults to 1. It is cleared when a `pop` leaves the count one below the trigger, or when `irq_clr` is pulsed. A push that moves the count past the trigger leaves it unchanged.
- R7: A `break_evt` pulse with `loopback`=0 stores the entry 0x400 (break bit set, data zero). With `loopback`=1 it stores nothing.
- R8: A push while full with no `pop` is dropped, and bit 11 of the newest stored entry is set. `rx_full` stays 1.
- R9: A `pop` copies bits [11:8] of the entry it reads into `rx_status` (bit 0 framing, bit 1 parity, bit 2 break, bit 3 overrun). A `stat_clr` pulse clears `rx_status`.
- R10: A push and a `pop` in the same cycle while full both take effect. The count stays at full, the new entry goes in last, and no overrun is marked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_en | input | 1 | Queue-enable level from the line control register |
| loopback | input | 1 | Loopback mode active; suppresses break entries |
| push_valid | input | 1 | Receiver delivers a character this cycle |
| push_data | input | 8 | Received character |
| push_frame_err | input | 1 | Framing error for the character |
| push_parity_err | input | 1 | Parity error for the character |
| break_evt | input | 1 | Line break detected (one-cycle pulse) |
| pop | input | 1 | Data register read |
| stat_clr | input | 1 | Write to the receive status register |
| irq_clr | input | 1 | Clear the receive-level interrupt |
| rd_entry | output | 12 | Oldest entry: data and error flags |
| rx_status | output | 4 | Error flags of the last entry read |
| rx_empty | output | 1 | Queue empty |
| rx_full | output | 1 | Queue full |
| can_accept | output | 1 | Receiver may deliver a character |
| rx_irq | output | 1 | Receive-level interrupt request |
| tx_flush | output | 1 | Mode change in progress; transmit flags reset |

## Verification
On every cycle the assertions check that the flags never contradict each other and that the count never exceeds the effective depth. They also check that a mode change leaves the queue empty, that a full queue stays full under pushes without a pop, that an empty pop keeps the queue empty, and that the interrupt rises only after a push. Data order across pointer wrap needs the bench's scenarios, as do the overrun bit landing on the right entry and the break-entry encoding. The status capture, the single-entry mode and the simultaneous push and pop at full are also left to the bench.

// File: rtl/uart_rx_queue.sv
module uart_rx_queue #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter int TRIG  = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_en,
  input  logic          loopback,
  input  logic          push_valid,
  input  logic [DW-1:0] push_data,
  input  logic          push_frame_err,
  input  logic          push_parity_err,
  input  logic          break_evt,
  input  logic          pop,
  input  logic          stat_clr,
  input  logic          irq_clr,
  output logic [DW+3:0] rd_entry,
  output logic [3:0]    rx_status,
  output logic          rx_empty,
  output logic          rx_full,
  output logic          can_accept,
  output logic          rx_irq,
  output logic          tx_flush
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int EW = DW + 4;

  logic [EW-1:0] mem [DEPTH];
  logic          mode_q;
  logic [AW-1:0] rp;
  logic [CW-1:0] cnt;
  logic [3:0]    stat_q;
  logic          irq_q;

  logic [CW-1:0] depth_eff, cnt_nx;
  logic [AW-1:0] mask, wslot, newest;
  logic [EW-1:0] new_entry;
  logic          brk_push, push_req, pop_ok, push_ok, ovf;

  assign tx_flush   = fifo_en ^ mode_q;
  assign depth_eff  = mode_q ? CW'(DEPTH) : CW'(1);
  assign mask       = mode_q ? AW'(DEPTH - 1) : '0;
  assign brk_push   = break_evt & ~loopback;
  assign push_req   = push_valid | brk_push;
  assign new_entry  = brk_push ? {1'b0, 1'b1, 2'b00, {DW{1'b0}}}
                               : {1'b0, 1'b0, push_parity_err, push_frame_err, push_data};

  assign rx_empty   = (cnt == '0);
  assign rx_full    = (cnt == depth_eff);
  assign can_accept = (cnt < depth_eff);
  assign pop_ok     = pop & ~rx_empty & ~tx_flush;
  assign push_ok    = push_req & (~rx_full | pop_ok) & ~tx_flush;
  assign ovf        = push_req & rx_full & ~pop_ok & ~tx_flush;
  assign cnt_nx     = cnt + CW'(push_ok) - CW'(pop_ok);
  assign wslot      = (rp + cnt[AW-1:0]) & mask;
  assign newest     = (rp + cnt[AW-1:0] - AW'(1)) & mask;

  assign rd_entry   = mem[rp];
  assign rx_status  = stat_q;
  assign rx_irq     = irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      rp     <= '0;
      cnt    <= '0;
    end else if (tx_flush) begin
      mode_q <= fifo_en;
      rp     <= '0;
      cnt    <= '0;
    end else begin
      cnt <= cnt_nx;
      if (pop_ok) rp <= (rp + AW'(1)) & mask;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (push_ok) begin
      mem[wslot] <= new_entry;
    end else if (ovf) begin
      mem[newest][EW-1] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (pop && !tx_flush) stat_q <= rd_entry[EW-1:DW];
      else if (stat_clr)    stat_q <= '0;

      if (push_ok && cnt_nx == CW'(TRIG))
        irq_q <= 1'b1;
      else if ((pop && !tx_flush && cnt_nx + CW'(1) == CW'(TRIG)) || irq_clr)
        irq_q <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_rx_queue_chk.sv
module uart_rx_queue_chk #(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fifo_en,
  input logic          loopback,
  input logic          push_valid,
  input logic          break_evt,
  input logic          pop,
  input logic          rx_empty,
  input logic          rx_full,
  input logic          can_accept,
  input logic          rx_irq,
  input logic          mode_q,
  input logic [CW-1:0] cnt
);
  a_r2_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_empty && rx_full));

  a_r2_accept_vs_full: assert property (@(posedge clk) disable iff (!rst_n)
    can_accept == !rx_full);

  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= (mode_q ? CW'(DEPTH) : CW'(1)));

  a_r5_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en != mode_q) |=> rx_empty);

  a_r4_empty_pop_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_empty && pop && !push_valid && !break_evt && fifo_en == mode_q) |=> rx_empty);

  a_r8_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && !pop && fifo_en == mode_q) |=> rx_full);

  a_r6_irq_needs_push: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_irq) |-> $past(push_valid || (break_evt && !loopback)));
endmodule

bind uart_rx_queue uart_rx_queue_chk #(.DEPTH(DEPTH), .CW($clog2(DEPTH + 1))) u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .loopback(loopback),
  .push_valid(push_valid), .break_evt(break_evt), .pop(pop),
  .rx_empty(rx_empty), .rx_full(rx_full), .can_accept(can_accept),
  .rx_irq(rx_irq), .mode_q(mode_q), .cnt(cnt)
);

// File: tb/uart_rx_queue_test.sv
module uart_rx_queue_test;
  logic clk = 1'b0;
  logic rst_n, fifo_en, loopback, push_valid, push_frame_err, push_parity_err;
  logic break_evt, pop, stat_clr, irq_clr;
  logic [7:0]  push_data;
  logic [11:0] rd_entry;
  logic [3:0]  rx_status;
  logic rx_empty, rx_full, can_accept, rx_irq, tx_flush;
  int tests = 0, fails = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  uart_rx_queue uut (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .loopback(loopback),
    .push_valid(push_valid), .push_data(push_data), .push_frame_err(push_frame_err),
    .push_parity_err(push_parity_err), .break_evt(break_evt), .pop(pop),
    .stat_clr(stat_clr), .irq_clr(irq_clr), .rd_entry(rd_entry), .rx_status(rx_status),
    .rx_empty(rx_empty), .rx_full(rx_full), .can_accept(can_accept),
    .rx_irq(rx_irq), .tx_flush(tx_flush)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] ent(logic ovr, logic brk, logic pe, logic fe, logic [7:0] d);
    return {ovr, brk, pe, fe, d};
  endfunction

  task automatic do_push(logic [7:0] d, logic fe, logic pe);
    push_valid = 1'b1; push_data = d; push_frame_err = fe; push_parity_err = pe;
    @(negedge clk);
    push_valid = 1'b0; push_frame_err = 1'b0; push_parity_err = 1'b0;
  endtask

  task automatic do_pop(output logic [11:0] e);
    e = rd_entry;
    pop = 1'b1;
    @(negedge clk);
    pop = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests + 1, fails);
      $finish;
    end
  end

  initial begin
    logic [11:0] e;
    rst_n = 0; fifo_en = 0; loopback = 0; push_valid = 0; push_data = 0;
    push_frame_err = 0; push_parity_err = 0; break_evt = 0; pop = 0;
    stat_clr = 0; irq_clr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 empty", rx_empty, 1);
    check("R1 full", rx_full, 0);
    check("R1 accept", can_accept, 1);
    check("R1 irq", rx_irq, 0);
    check("R1 status", rx_status, 0);
    check("R1 flush", tx_flush, 0);

    fifo_en = 1; #1;
    check("R5 flush pulse", tx_flush, 1);
    @(negedge clk);
    check("R5 flush done", tx_flush, 0);
    check("R5 empty after mode change", rx_empty, 1);

    for (int k = 0; k < 16; k++) begin
      do_push(8'(8'h30 + k), (k % 3) == 1, (k % 5) == 2);
      check("R2 not empty", rx_empty, 0);
      check("R2 full at 16", rx_full, k == 15);
      check("R2 accept below 16", can_accept, k != 15);
      check("R6 irq set at trigger", rx_irq, 1);
    end
    do_push(8'hEE, 0, 0);
    check("R8 full after overflow", rx_full, 1);
    for (int k = 0; k < 16; k++) begin
      do_pop(e);
      check("R3/R8 order and overrun", e,
            ent(k == 15, 0, (k % 5) == 2, (k % 3) == 1, 8'(8'h30 + k)));
      check("R9 status capture", rx_status, {4'(0) | e[11:8]});
      check("R6 irq until count falls below trigger", rx_irq, k != 15);
      check("R2 empty at end", rx_empty, k == 15);
    end
    do_pop(e);
    check("R4 empty pop empty", rx_empty, 1);
    check("R4 empty pop not full", rx_full, 0);

    do_push(8'h77, 1, 1);
    do_pop(e);
    check("R9 status fe+pe", rx_status, 4'b0011);
    stat_clr = 1; @(negedge clk); stat_clr = 0;
    check("R9 status cleared", rx_status, 0);

    for (int s = 0; s < 16; s++) begin
      int n = (s % 7) + 1;
      for (int j = 0; j < n; j++) do_push(8'(s * 16 + j), 0, 0);
      for (int j = 0; j < n; j++) begin
        do_pop(e);
        check("R3 wrap order", e, ent(0, 0, 0, 0, 8'(s * 16 + j)));
      end
    end

    do_push(8'h01, 0, 0);
    check("R6 irq after first push", rx_irq, 1);
    irq_clr = 1; @(negedge clk); irq_clr = 0;
    check("R6 irq_clr", rx_irq, 0);
    do_push(8'h02, 0, 0);
    check("R6 no set past trigger", rx_irq, 0);
    do_pop(e); do_pop(e);
    check("R6 irq low when drained", rx_irq, 0);

    for (int j = 0; j < 16; j++) do_push(8'(j), 0, 0);
    e = rd_entry; push_valid = 1; push_data = 8'hAA; pop = 1;
    @(negedge clk);
    push_valid = 0; pop = 0;
    check("R10 popped head", e, ent(0, 0, 0, 0, 8'h00));
    check("R10 still full", rx_full, 1);
    for (int j = 1; j < 17; j++) begin
      do_pop(e);
      check("R10 order after simultaneous", e, ent(0, 0, 0, 0, j == 16 ? 8'hAA : 8'(j)));
    end

    for (int j = 0; j < 3; j++) do_push(8'(j), 0, 0);
    fifo_en = 0; #1;
    check("R5 flush pulse on disable", tx_flush, 1);
    @(negedge clk);
    check("R5 emptied on disable", rx_empty, 1);
    do_push(8'h5A, 0, 0);
    check("R2 single entry full", rx_full, 1);
    check("R2 single entry accept", can_accept, 0);
    do_push(8'h66, 0, 0);
    check("R8 single full holds", rx_full, 1);
    do_pop(e);
    check("R8 single overrun marked", e, 12'h85A);
    check("R2 single empty after pop", rx_empty, 1);
    do_push(8'h11, 0, 0);
    do_pop(e);
    check("R3 single slot reuse", e, 12'h011);
    do_pop(e);
    check("R4 empty pop single mode", rx_empty, 1);

    break_evt = 1; @(negedge clk); break_evt = 0;
    check("R7 break stored", rx_empty, 0);
    do_pop(e);
    check("R7 break entry", e, 12'h400);
    check("R9 break status", rx_status, 4'b0100);
    loopback = 1;
    break_evt = 1; @(negedge clk); break_evt = 0;
    check("R7 break ignored in loopback", rx_empty, 1);
    loopback = 0;

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule